// File: doc/BRIEF.md
# Single-Cycle Integer Subset Processor

This block is a small 32-bit processor that completes one instruction per enabled clock. It runs eighteen integer operations: register and immediate arithmetic and logic, shifts, a signed compare, equal and not-equal branches, absolute and register jumps, a jump that saves its return address, and word loads and stores. Code and data share one word memory whose base byte address is 0x00400000. A write port fills that memory before execution starts. The program counter and the stack register come out of reset at fixed values.

Each retired instruction is reported on the cycle after it executes. The report gives the instruction's address, the register it wrote and the value written, and the memory word it stored, if there was one. A testbench can therefore follow execution step by step, in the way a software instruction-set model prints state changes. An opcode outside the supported set stops the core. It raises a sticky halted flag and changes no state.

Top module: `rcore_top`

## Requirements
- R1: Synchronous reset sets the program counter to 0x00400000, register 29 to 0x00404000 and every other register to zero. After reset, halted, retire, rf_chg and mem_chg are low.
- R2: While ld_en is high, ld_data is written to memory word ld_word, which holds byte address 0x00400000 + 4*ld_word. Instructions are fetched from that memory at the program counter.
- R3: Each clock with step high and halted low executes exactly one instruction. On the next cycle retire pulses high for one cycle, with retire_pc holding that instruction's address. While step is low, nothing changes and retire stays low.
- R4: Opcode [31:26]=0 selects a register operation by funct [5:0]. The sources are rs [25:21] and rt [20:16] and the destination is rd [15:11]. The funct codes are: 0x21 add, 0x23 subtract (rs-rt), 0x24 and, 0x25 or, 0x2A signed rs<rt giving 1 or 0, 0x00 rt shifted left by shamt [10:6], and 0x02 rt shifted right logically by shamt.
- R5: The immediate operations take rs and the 16-bit field [15:0] and write rt. The opcodes are: 0x09 add with a sign-extended immediate, 0x0C and with a zero-extended immediate, 0x0D or with a zero-extended immediate, and 0x0F, which writes the immediate into the upper half of rt and clears the lower half.
- R6: Opcode 0x04 branches when rs==rt and opcode 0x05 branches when rs!=rt. The target is PC+4 plus the sign-extended immediate shifted left by two. The next instruction executed is either the target or PC+4, with no delay slot.
- R7: Opcode 0x02 jumps to {PC+4[31:28], field[25:0], 2'b00}. Opcode 0x03 does the same jump and also writes PC+4 into register 31. Opcode 0 with funct 0x08 jumps to the value in rs.
- R8: Opcode 0x23 loads into rt the word at byte address rs + sext(imm). Opcode 0x2B stores rt at that address.
- R9: Register 0 always reads as zero. A write to it is discarded and is not reported in rf_chg.
- R10: rf_chg (with rf_chg_idx and rf_chg_val) is reported only for the instructions that write a register. mem_chg (with mem_chg_addr as a byte address and mem_chg_val) is reported only for a store. Neither is ever reported without retire.
- R11: Any other opcode or funct sets halted on the next cycle, without retire or any register, memory or PC change. halted stays high until reset, and further steps have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Execute one instruction this clock |
| ld_en | input | 1 | Memory fill write enable |
| ld_word | input | 12 | Memory fill word index |
| ld_data | input | 32 | Memory fill data |
| halted | output | 1 | Unsupported instruction met; core stopped |
| retire | output | 1 | One instruction completed last cycle |
| retire_pc | output | 32 | Address of the completed instruction |
| rf_chg | output | 1 | Completed instruction wrote a register |
| rf_chg_idx | output | 5 | Register written |
| rf_chg_val | output | 32 | Value written |
| mem_chg | output | 1 | Completed instruction stored a word |
| mem_chg_addr | output | 32 | Byte address stored |
| mem_chg_val | output | 32 | Word stored |

## Verification
Every register write and every store appears on the report ports in the cycle right after the step. A wrong ALU result, a wrong extension of an immediate, or a corrupted register shows up within one step as a mismatched rf_chg_val, or later, when that register is read and its value passes on. A wrong branch or jump target shows up as an unexpected retire_pc on the very next step. A wrong decode of an illegal opcode shows up either as a retire where halted was expected, or as halted rising early in a program of legal instructions.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_J    = 6'h02;
  localparam logic [5:0] OPC_JAL  = 6'h03;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BNE  = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h09;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LUI  = 6'h0F;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h21;
  localparam logic [5:0] FN_SUB = 6'h23;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [4:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_AND, OP_OR, OP_SLT,
    OP_ADDI, OP_ANDI, OP_ORI, OP_LUI,
    OP_BEQ, OP_BNE, OP_J, OP_JAL, OP_JR,
    OP_LW, OP_SW, OP_BAD
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [4:0]  dst;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic [25:0] jidx;
    logic        wr_reg;
  } dec_t;
endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    dec.rs     = instr[25:21];
    dec.rt     = instr[20:16];
    dec.sh     = instr[10:6];
    dec.imm    = instr[15:0];
    dec.jidx   = instr[25:0];
    dec.dst    = instr[20:16];
    dec.wr_reg = 1'b0;
    dec.op     = OP_BAD;
    unique case (opc)
      OPC_REG: begin
        dec.dst    = instr[15:11];
        dec.wr_reg = 1'b1;
        unique case (fn)
          FN_ADD:  dec.op = OP_ADD;
          FN_SUB:  dec.op = OP_SUB;
          FN_AND:  dec.op = OP_AND;
          FN_OR:   dec.op = OP_OR;
          FN_SLT:  dec.op = OP_SLT;
          FN_SLL:  dec.op = OP_SLL;
          FN_SRL:  dec.op = OP_SRL;
          FN_JR: begin
            dec.op     = OP_JR;
            dec.wr_reg = 1'b0;
          end
          default: begin
            dec.op     = OP_BAD;
            dec.wr_reg = 1'b0;
          end
        endcase
      end
      OPC_ADDI: begin dec.op = OP_ADDI; dec.wr_reg = 1'b1; end
      OPC_ANDI: begin dec.op = OP_ANDI; dec.wr_reg = 1'b1; end
      OPC_ORI:  begin dec.op = OP_ORI;  dec.wr_reg = 1'b1; end
      OPC_LUI:  begin dec.op = OP_LUI;  dec.wr_reg = 1'b1; end
      OPC_LW:   begin dec.op = OP_LW;   dec.wr_reg = 1'b1; end
      OPC_SW:   dec.op = OP_SW;
      OPC_BEQ:  dec.op = OP_BEQ;
      OPC_BNE:  dec.op = OP_BNE;
      OPC_J:    dec.op = OP_J;
      OPC_JAL: begin
        dec.op     = OP_JAL;
        dec.dst    = LINK_REG;
        dec.wr_reg = 1'b1;
      end
      default:  dec.op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int W = XLEN
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   sh,
  input  logic [15:0]  imm,
  output logic [W-1:0] res
);
  logic [W-1:0] imm_s;
  logic [W-1:0] imm_z;

  assign imm_s = {{(W-16){imm[15]}}, imm};
  assign imm_z = {{(W-16){1'b0}}, imm};

  always_comb begin
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_SLT:  res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      OP_SLL:  res = b << sh;
      OP_SRL:  res = b >> sh;
      OP_ADDI: res = a + imm_s;
      OP_ANDI: res = a & imm_z;
      OP_ORI:  res = a | imm_z;
      OP_LUI:  res = {imm, {(W-16){1'b0}}};
      OP_LW,
      OP_SW:   res = a + imm_s;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int              NREG    = 32,
  parameter int              W       = 32,
  parameter int              SP_IDX  = 29,
  parameter logic [W-1:0]    SP_INIT = 32'h0040_4000,
  localparam int             AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/rcore_umem.sv
module rcore_umem #(
  parameter int  WORDS = 4096,
  parameter int  W     = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [AW-1:0] i_idx,
  output logic [W-1:0]  i_data,
  input  logic [AW-1:0] d_idx,
  output logic [W-1:0]  d_data,
  input  logic          we,
  input  logic [AW-1:0] w_idx,
  input  logic [W-1:0]  w_data
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_data;
  end

  assign i_data = mem[i_idx];
  assign d_data = mem[d_idx];
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int           MEM_WORDS = 4096,
  parameter logic [31:0]  MEM_BASE  = 32'h0040_0000,
  parameter logic [31:0]  PC_RESET  = 32'h0040_0000,
  parameter logic [31:0]  SP_RESET  = 32'h0040_4000,
  localparam int          AW        = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_word,
  input  logic [31:0]   ld_data,
  output logic          halted,
  output logic          retire,
  output logic [31:0]   retire_pc,
  output logic          rf_chg,
  output logic [4:0]    rf_chg_idx,
  output logic [31:0]   rf_chg_val,
  output logic          mem_chg,
  output logic [31:0]   mem_chg_addr,
  output logic [31:0]   mem_chg_val
);
  logic [31:0]   pc_q;
  logic [31:0]   pc4;
  logic [31:0]   br_tgt;
  logic [31:0]   j_tgt;
  logic [31:0]   pc_nxt;
  logic [31:0]   instr;
  dec_t          dec;
  logic [31:0]   rs_val;
  logic [31:0]   rt_val;
  logic [31:0]   alu_res;
  logic [31:0]   ld_val;
  logic [31:0]   wr_val;
  logic [AW-1:0] f_idx;
  logic [AW-1:0] d_idx;
  logic          fire;
  logic          commit;
  logic          rf_we;
  logic          st_we;
  logic          m_we;
  logic [AW-1:0] m_widx;
  logic [31:0]   m_wdata;

  assign f_idx = AW'((pc_q - MEM_BASE) >> 2);
  assign d_idx = AW'((alu_res - MEM_BASE) >> 2);

  rcore_umem #(.WORDS(MEM_WORDS), .W(32)) u_mem (
    .clk    (clk),
    .i_idx  (f_idx),
    .i_data (instr),
    .d_idx  (d_idx),
    .d_data (ld_val),
    .we     (m_we),
    .w_idx  (m_widx),
    .w_data (m_wdata)
  );

  rcore_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  rcore_regfile #(.NREG(32), .W(32), .SP_IDX(29), .SP_INIT(SP_RESET)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (dec.rs),
    .ra_b (dec.rt),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .we   (rf_we),
    .wa   (dec.dst),
    .wd   (wr_val)
  );

  rcore_alu #(.W(32)) u_alu (
    .op  (dec.op),
    .a   (rs_val),
    .b   (rt_val),
    .sh  (dec.sh),
    .imm (dec.imm),
    .res (alu_res)
  );

  assign pc4    = pc_q + 32'd4;
  assign br_tgt = pc4 + {{14{dec.imm[15]}}, dec.imm, 2'b00};
  assign j_tgt  = {pc4[31:28], dec.jidx, 2'b00};

  always_comb begin
    unique case (dec.op)
      OP_BEQ:       pc_nxt = (rs_val == rt_val) ? br_tgt : pc4;
      OP_BNE:       pc_nxt = (rs_val != rt_val) ? br_tgt : pc4;
      OP_J, OP_JAL: pc_nxt = j_tgt;
      OP_JR:        pc_nxt = rs_val;
      default:      pc_nxt = pc4;
    endcase
  end

  always_comb begin
    unique case (dec.op)
      OP_JAL:  wr_val = pc4;
      OP_LW:   wr_val = ld_val;
      default: wr_val = alu_res;
    endcase
  end

  assign fire    = step && !halted;
  assign commit  = fire && (dec.op != OP_BAD);
  assign rf_we   = commit && dec.wr_reg && (dec.dst != '0);
  assign st_we   = commit && (dec.op == OP_SW);
  assign m_we    = ld_en || st_we;
  assign m_widx  = ld_en ? ld_word : d_idx;
  assign m_wdata = ld_en ? ld_data : rt_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= PC_RESET;
      halted       <= 1'b0;
      retire       <= 1'b0;
      retire_pc    <= '0;
      rf_chg       <= 1'b0;
      rf_chg_idx   <= '0;
      rf_chg_val   <= '0;
      mem_chg      <= 1'b0;
      mem_chg_addr <= '0;
      mem_chg_val  <= '0;
    end else begin
      retire  <= commit;
      rf_chg  <= rf_we;
      mem_chg <= st_we;
      if (fire && (dec.op == OP_BAD)) halted <= 1'b1;
      if (commit) begin
        pc_q      <= pc_nxt;
        retire_pc <= pc_q;
      end
      if (rf_we) begin
        rf_chg_idx <= dec.dst;
        rf_chg_val <= wr_val;
      end
      if (st_we) begin
        mem_chg_addr <= alu_res;
        mem_chg_val  <= rt_val;
      end
    end
  end
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic       clk,
  input logic       rst,
  input logic       step,
  input logic       halted,
  input logic       retire,
  input logic       rf_chg,
  input logic [4:0] rf_chg_idx,
  input logic       mem_chg
);
  // R9
  zero_reg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rf_chg |-> (rf_chg_idx != 5'd0));

  // R10
  store_report_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_chg |-> (retire && !rf_chg));

  // R10
  reg_report_ret_chk: assert property (@(posedge clk) disable iff (rst)
    rf_chg |-> retire);

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!retire && !rf_chg && !mem_chg));

  // R3
  retire_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
    retire |-> $past(step));
endmodule

bind rcore_top rcore_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .halted     (halted),
  .retire     (retire),
  .rf_chg     (rf_chg),
  .rf_chg_idx (rf_chg_idx),
  .mem_chg    (mem_chg)
);

// File: tb/sim_rcore_top.sv
module sim_rcore_top;
  localparam int          WORDS = 4096;
  localparam logic [31:0] BASE  = 32'h0040_0000;
  localparam int          NRAND = 140;

  logic        clk = 1'b0;
  logic        rst;
  logic        step;
  logic        ld_en;
  logic [11:0] ld_word;
  logic [31:0] ld_data;
  logic        halted, retire, rf_chg, mem_chg;
  logic [31:0] retire_pc, rf_chg_val, mem_chg_addr, mem_chg_val;
  logic [4:0]  rf_chg_idx;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rcore_top u0 (
    .clk(clk), .rst(rst), .step(step), .ld_en(ld_en), .ld_word(ld_word),
    .ld_data(ld_data), .halted(halted), .retire(retire), .retire_pc(retire_pc),
    .rf_chg(rf_chg), .rf_chg_idx(rf_chg_idx), .rf_chg_val(rf_chg_val),
    .mem_chg(mem_chg), .mem_chg_addr(mem_chg_addr), .mem_chg_val(mem_chg_val)
  );

  // reference state
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [WORDS];
  logic [31:0] m_pc;
  logic        m_halted;
  logic        exp_ret, exp_rf, exp_mc, exp_halt;
  logic [31:0] exp_pc, exp_rfv, exp_ma, exp_mv;
  logic [4:0]  exp_rfi;
  string       tag, rf_tag;

  function automatic logic [31:0] rtype(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] itype(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] jtype(logic [5:0] op, int word);
    logic [31:0] a;
    a = BASE + 32'(word * 4);
    return {op, a[27:2]};
  endfunction

  function automatic logic [31:0] rand_instr();
    logic [4:0]  d, s, t;
    logic [15:0] off;
    d = 5'($urandom_range(0, 28));
    s = 5'($urandom_range(0, 31));
    t = 5'($urandom_range(0, 31));
    off = 16'(-(4 * int'($urandom_range(1, 512))));
    case ($urandom_range(0, 12))
      0:  return rtype(6'h21, s, t, d, 5'd0);
      1:  return rtype(6'h23, s, t, d, 5'd0);
      2:  return rtype(6'h24, s, t, d, 5'd0);
      3:  return rtype(6'h25, s, t, d, 5'd0);
      4:  return rtype(6'h2A, s, t, d, 5'd0);
      5:  return rtype(6'h00, 5'd0, t, d, 5'($urandom_range(0, 31)));
      6:  return rtype(6'h02, 5'd0, t, d, 5'($urandom_range(0, 31)));
      7:  return itype(6'h09, s, d, 16'($urandom));
      8:  return itype(6'h0C, s, d, 16'($urandom));
      9:  return itype(6'h0D, s, d, 16'($urandom));
      10: return itype(6'h0F, 5'd0, d, 16'($urandom));
      11: return itype(6'h2B, 5'd29, t, off);
      default: return itype(6'h23, 5'd29, d, off);
    endcase
  endfunction

  task automatic ref_step();
    logic [31:0] ins, a, b, p4, nxt, res, sx;
    logic [5:0]  opc, fn;
    logic [4:0]  rs, rt, dst;
    logic        wr, bad, st;
    exp_ret = 1'b0; exp_rf = 1'b0; exp_mc = 1'b0; exp_halt = m_halted;
    exp_pc = m_pc; rf_tag = "R10"; tag = "R11";
    if (m_halted) return;
    ins = m_mem[int'((m_pc - BASE) >> 2)];
    opc = ins[31:26]; fn = ins[5:0]; rs = ins[25:21]; rt = ins[20:16];
    a = m_reg[rs]; b = m_reg[rt]; p4 = m_pc + 4; nxt = p4;
    sx = {{16{ins[15]}}, ins[15:0]};
    wr = 1'b1; bad = 1'b0; st = 1'b0; dst = rt; res = '0;
    case (opc)
      6'h00: begin
        dst = ins[15:11]; tag = "R4";
        case (fn)
          6'h21: res = a + b;
          6'h23: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          6'h00: res = b << ins[10:6];
          6'h02: res = b >> ins[10:6];
          6'h08: begin wr = 1'b0; nxt = a; tag = "R7"; end
          default: bad = 1'b1;
        endcase
      end
      6'h09: begin res = a + sx; tag = "R5"; end
      6'h0C: begin res = a & {16'h0, ins[15:0]}; tag = "R5"; end
      6'h0D: begin res = a | {16'h0, ins[15:0]}; tag = "R5"; end
      6'h0F: begin res = {ins[15:0], 16'h0}; tag = "R5"; end
      6'h04: begin wr = 1'b0; tag = "R6"; if (a == b) nxt = p4 + (sx << 2); end
      6'h05: begin wr = 1'b0; tag = "R6"; if (a != b) nxt = p4 + (sx << 2); end
      6'h02: begin wr = 1'b0; tag = "R7"; nxt = {p4[31:28], ins[25:0], 2'b00}; end
      6'h03: begin dst = 5'd31; res = p4; tag = "R7"; nxt = {p4[31:28], ins[25:0], 2'b00}; end
      6'h23: begin res = m_mem[int'((a + sx - BASE) >> 2)]; tag = "R8"; end
      6'h2B: begin wr = 1'b0; st = 1'b1; tag = "R8"; end
      default: bad = 1'b1;
    endcase
    if (bad) begin
      tag = "R11"; exp_halt = 1'b1; m_halted = 1'b1;
      return;
    end
    exp_ret = 1'b1;
    if (wr && dst == 5'd0) rf_tag = "R9";
    if (wr && dst != 5'd0) begin
      exp_rf = 1'b1; exp_rfi = dst; exp_rfv = res; m_reg[dst] = res;
    end
    if (st) begin
      exp_mc = 1'b1; exp_ma = a + sx; exp_mv = b;
      m_mem[int'((a + sx - BASE) >> 2)] = b;
    end
    m_pc = nxt;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_step();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
  endtask

  task automatic compare(bit first);
    chk("R3", "retire", 32'(retire), 32'(exp_ret));
    chk("R11", "halted", 32'(halted), 32'(exp_halt));
    if (exp_ret) chk(first ? "R1" : "R2", "retire_pc", retire_pc, exp_pc);
    chk(rf_tag, "rf_chg", 32'(rf_chg), 32'(exp_rf));
    if (exp_rf && rf_chg) begin
      chk(tag, "rf_chg_idx", 32'(rf_chg_idx), 32'(exp_rfi));
      chk(first ? "R1" : tag, "rf_chg_val", rf_chg_val, exp_rfv);
    end
    chk("R10", "mem_chg", 32'(mem_chg), 32'(exp_mc));
    if (exp_mc && mem_chg) begin
      chk("R8", "mem_chg_addr", mem_chg_addr, exp_ma);
      chk("R8", "mem_chg_val", mem_chg_val, exp_mv);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int n;
    logic [31:0] prog [200];
    void'($urandom(32'h5EED_0042));
    // directed part
    prog[0]  = rtype(6'h21, 5'd29, 5'd0, 5'd2, 5'd0);     // R1: sp value
    prog[1]  = rtype(6'h21, 5'd5, 5'd0, 5'd3, 5'd0);      // R1: zero reg
    prog[2]  = itype(6'h0F, 5'd0, 5'd4, 16'h8000);
    prog[3]  = itype(6'h0D, 5'd4, 5'd4, 16'hFFFF);
    prog[4]  = itype(6'h09, 5'd0, 5'd5, 16'hFFFD);
    prog[5]  = itype(6'h0C, 5'd5, 5'd6, 16'hF0F0);
    prog[6]  = rtype(6'h00, 5'd0, 5'd5, 5'd7, 5'd4);
    prog[7]  = rtype(6'h02, 5'd0, 5'd4, 5'd8, 5'd31);
    prog[8]  = rtype(6'h2A, 5'd5, 5'd8, 5'd9, 5'd0);
    prog[9]  = rtype(6'h2A, 5'd8, 5'd5, 5'd10, 5'd0);
    prog[10] = rtype(6'h23, 5'd0, 5'd8, 5'd11, 5'd0);
    prog[11] = rtype(6'h24, 5'd4, 5'd5, 5'd12, 5'd0);
    prog[12] = rtype(6'h25, 5'd6, 5'd8, 5'd13, 5'd0);
    prog[13] = itype(6'h2B, 5'd29, 5'd4, 16'hFFFC);
    prog[14] = itype(6'h23, 5'd29, 5'd14, 16'hFFFC);
    prog[15] = itype(6'h09, 5'd0, 5'd0, 16'h0005);         // R9
    prog[16] = rtype(6'h21, 5'd0, 5'd0, 5'd15, 5'd0);      // R9
    prog[17] = itype(6'h04, 5'd9, 5'd8, 16'h0001);         // taken
    prog[18] = itype(6'h09, 5'd0, 5'd20, 16'h0055);        // skipped
    prog[19] = itype(6'h05, 5'd9, 5'd8, 16'h0005);         // not taken
    prog[20] = jtype(6'h03, 24);
    prog[21] = jtype(6'h02, 26);
    prog[22] = itype(6'h09, 5'd0, 5'd20, 16'h0066);
    prog[23] = itype(6'h09, 5'd0, 5'd20, 16'h0077);
    prog[24] = itype(6'h09, 5'd31, 5'd21, 16'h0000);
    prog[25] = rtype(6'h08, 5'd31, 5'd0, 5'd0, 5'd0);
    prog[26] = jtype(6'h02, 28);
    prog[27] = itype(6'h04, 5'd0, 5'd0, 16'h0002);         // to 30
    prog[28] = itype(6'h04, 5'd0, 5'd0, 16'hFFFE);         // back to 27
    prog[29] = itype(6'h09, 5'd0, 5'd20, 16'h0088);
    for (int i = 30; i < 30 + NRAND; i++) prog[i] = rand_instr();
    prog[30 + NRAND] = 32'hFC00_0000;                      // R11 unsupported
    for (int i = 31 + NRAND; i < 200; i++) prog[i] = 32'h0;

    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_reg[29] = 32'h0040_4000;
    m_pc = BASE; m_halted = 1'b0;

    rst = 1'b1; step = 1'b0; ld_en = 1'b0; ld_word = '0; ld_data = '0;
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_word = 12'(i);
      ld_data = (i < 200) ? prog[i] : $urandom;
      m_mem[i] = ld_data;                                  // R2 fill
    end
    @(negedge clk) ld_en = 1'b0;
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1", "halted after reset", 32'(halted), 32'd0);
    chk("R1", "retire after reset", 32'(retire), 32'd0);
    chk("R1", "rf_chg after reset", 32'(rf_chg), 32'd0);
    chk("R1", "mem_chg after reset", 32'(mem_chg), 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3", "retire while idle", 32'(retire), 32'd0);
    end

    n = 0;
    while (!m_halted && n < 600) begin
      ref_step();
      do_step();
      compare(n == 0);
      n++;
    end
    chk("R11", "reached unsupported word", 32'(m_halted), 32'd1);
    for (int i = 0; i < 3; i++) begin
      ref_step();
      do_step();
      chk("R11", "halted stays", 32'(halted), 32'd1);
      chk("R11", "no retire once halted", 32'(retire), 32'd0);
      chk("R11", "no reg change once halted", 32'(rf_chg), 32'd0);
      chk("R11", "no store once halted", 32'(mem_chg), 32'd0);
    end
    report();
    $finish;
  end
endmodule